// File: doc/BRIEF.md
# Predicated SIMD Lane Group Sequencer

This block walks a short vector of narrow elements through a fixed-width SIMD ALU one lane group at a time. A request carries a vector length and a predicate mask with one bit per element. The sequencer then issues groups in ascending order. With each group it sends the group index, a per-lane enable and a flag that marks the final group. Predicate bits are not compacted. Each lane's enable is its own predicate bit, further masked off when the element lies past the end of the vector.

The number of groups is the vector length divided by the lane count, rounded up. A group in which every lane is disabled is still issued, so the number of handshakes depends only on the vector length. With the default four lanes, a 9-element vector takes three groups, and in the third group only lane 0 can be enabled.

Both edges are valid/ready streams. A request is taken when `start_valid` and `start_ready` are both high. `start_ready` is high only while no vector is in progress. A group is consumed when `grp_valid` and `grp_ready` are both high. While `grp_valid` is high and `grp_ready` is low, the group outputs hold steady and `grp_valid` stays high. Requests offered while busy are not taken.

Top module: `lane_group_seq`

## Requirements
- R1: After reset `grp_valid` is 0 and `start_ready` is 1.
- R2: An accepted request with vector length N (1..MAX_VL) produces ceil(N/LANES) groups. Their indices are 0, 1, 2, ... in order, and each group lasts exactly one `grp_ready` handshake. The first group is presented in the cycle after the request is accepted.
- R3: In group g, bit l of `grp_lane_en` (lane l) equals bit (g*LANES + l) of `start_pred` ANDed with (g*LANES + l < N). Element e of the vector maps to predicate bit e.
- R4: A group whose enables are all zero is still presented with `grp_valid` high and needs its own handshake.
- R5: `grp_last` is 1 only on the final group. In the cycle after that group's handshake, `grp_valid` is 0 and `start_ready` is 1.
- R6: While `grp_valid` is 1 and `grp_ready` is 0, `grp_valid` stays 1 and `grp_idx`, `grp_lane_en` and `grp_last` do not change.
- R7: While a vector is in progress, `start_ready` is 0. A request offered then has no effect on the groups of the current vector.
- R8: A request with length 0 is accepted, produces no group, and leaves the block ready for a new request.
- R9: A length above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request offered |
| start_ready | output | 1 | Request can be taken (idle) |
| start_vl | input | VL_W (5) | Vector length in elements |
| start_pred | input | MAX_VL (16) | Predicate, bit e for element e |
| grp_valid | output | 1 | A group is presented |
| grp_ready | input | 1 | Consumer takes the group |
| grp_idx | output | GRP_W (2) | Index of the presented group |
| grp_lane_en | output | LANES (4) | Per-lane enable, bit l for lane l |
| grp_last | output | 1 | Presented group is the final one |

## Verification
The hardest case to reach is a request that arrives while a vector is still running, combined with consumer stalls. The request must leave the captured length and predicate untouched, and the outputs must freeze during each stall. The stimulus gets there by holding `start_valid` high with a different length and predicate through a whole run. In the same runs, `grp_ready` is dropped for one cycle on every group, so each presented group is checked before and after a stall. Lengths that are not a multiple of the lane count, a length over the maximum, and an all-zero predicate group cover the end-of-vector masking and the fixed group count.

// File: rtl/lgs_pkg.sv
package lgs_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lgs_group_ctrl.sv
module lgs_group_ctrl #(
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  parameter int VL_W   = 5,
  parameter int GRP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [VL_W-1:0]   start_vl,
  input  logic [MAX_VL-1:0] start_pred,
  input  logic              grp_ready,
  output logic              busy,
  output logic [GRP_W-1:0]  grp_q,
  output logic              last,
  output logic [VL_W-1:0]   vl_q,
  output logic [MAX_VL-1:0] pred_q
);
  import lgs_pkg::*;

  seq_state_e       state_q;
  logic [GRP_W-1:0] last_q;
  logic [VL_W-1:0]  vl_eff;
  int unsigned      ngrp;
  logic             accept;
  logic             step;

  always_comb begin
    vl_eff = (start_vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : start_vl;
    ngrp   = div_ceil(32'(vl_eff), LANES);
    accept = start_valid && (state_q == ST_IDLE);
    step   = (state_q == ST_RUN) && grp_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      last_q  <= '0;
      vl_q    <= '0;
      pred_q  <= '0;
    end else if (accept) begin
      vl_q    <= vl_eff;
      pred_q  <= start_pred;
      grp_q   <= '0;
      last_q  <= GRP_W'(ngrp - 32'd1);
      state_q <= (vl_eff == '0) ? ST_IDLE : ST_RUN;
    end else if (step) begin
      if (grp_q == last_q) begin
        state_q <= ST_IDLE;
      end else begin
        grp_q <= grp_q + 1'b1;
      end
    end
  end

  assign busy = (state_q == ST_RUN);
  assign last = busy && (grp_q == last_q);

endmodule

// File: rtl/lgs_lane_mask.sv
module lgs_lane_mask #(
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  parameter int VL_W   = 5,
  parameter int GRP_W  = 2
) (
  input  logic [GRP_W-1:0]  grp,
  input  logic [VL_W-1:0]   vl,
  input  logic [MAX_VL-1:0] pred,
  output logic [LANES-1:0]  lane_en
);
  localparam int NGRP_MAX = (MAX_VL + LANES - 1) / LANES;
  localparam int PAD_W    = NGRP_MAX * LANES;
  localparam int IDX_W    = $clog2(PAD_W) + 1;

  logic [PAD_W-1:0] pred_pad;
  assign pred_pad = PAD_W'(pred);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] elem;
    logic [PAD_W-1:0] shifted;
    logic             in_range;
    assign elem     = IDX_W'(grp) * IDX_W'(LANES) + IDX_W'(l);
    assign shifted  = pred_pad >> elem;
    assign in_range = elem < IDX_W'(vl);
    assign lane_en[l] = in_range && shifted[0];
  end

endmodule

// File: rtl/lane_group_seq.sv
module lane_group_seq #(
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int NGRP_MAX = (MAX_VL + LANES - 1) / LANES,
  localparam int GRP_W    = (NGRP_MAX > 1) ? $clog2(NGRP_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [VL_W-1:0]   start_vl,
  input  logic [MAX_VL-1:0] start_pred,
  output logic              grp_valid,
  input  logic              grp_ready,
  output logic [GRP_W-1:0]  grp_idx,
  output logic [LANES-1:0]  grp_lane_en,
  output logic              grp_last
);
  logic              busy;
  logic [GRP_W-1:0]  grp_q;
  logic              last;
  logic [VL_W-1:0]   vl_q;
  logic [MAX_VL-1:0] pred_q;
  logic [LANES-1:0]  en_raw;

  lgs_group_ctrl #(
    .LANES(LANES), .MAX_VL(MAX_VL), .VL_W(VL_W), .GRP_W(GRP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_vl(start_vl), .start_pred(start_pred),
    .grp_ready(grp_ready),
    .busy(busy), .grp_q(grp_q), .last(last), .vl_q(vl_q), .pred_q(pred_q)
  );

  lgs_lane_mask #(
    .LANES(LANES), .MAX_VL(MAX_VL), .VL_W(VL_W), .GRP_W(GRP_W)
  ) u_mask (
    .grp(grp_q), .vl(vl_q), .pred(pred_q), .lane_en(en_raw)
  );

  assign start_ready = !busy;
  assign grp_valid   = busy;
  assign grp_idx     = grp_q;
  assign grp_lane_en = busy ? en_raw : '0;
  assign grp_last    = last;

endmodule

// File: rtl/lgs_seq_chk.sv
module lgs_seq_chk #(
  parameter int LANES = 4,
  parameter int VL_W  = 5,
  parameter int GRP_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_valid,
  input logic             start_ready,
  input logic [VL_W-1:0]  start_vl,
  input logic             grp_valid,
  input logic             grp_ready,
  input logic [GRP_W-1:0] grp_idx,
  input logic [LANES-1:0] grp_lane_en,
  input logic             grp_last
);
  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_ready) |=> (grp_valid && $stable(grp_idx) &&
                                    $stable(grp_lane_en) && $stable(grp_last)));

  // R5
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready && grp_last) |=> (!grp_valid && start_ready));

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready && !grp_last) |=>
      (grp_valid && grp_idx == $past(grp_idx) + 1'b1));

  // R2
  first_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_valid) |-> (grp_idx == '0));

  // R7
  no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> !start_ready);

  // R8
  empty_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && start_vl == '0) |=> (!grp_valid && start_ready));

endmodule

bind lane_group_seq lgs_seq_chk #(
  .LANES(LANES), .VL_W(VL_W), .GRP_W(GRP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_valid(start_valid), .start_ready(start_ready), .start_vl(start_vl),
  .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_idx(grp_idx),
  .grp_lane_en(grp_lane_en), .grp_last(grp_last)
);

// File: tb/tb_lane_group_seq.sv
module tb_lane_group_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [4:0]  start_vl = '0;
  logic [15:0] start_pred = '0;
  logic        grp_valid;
  logic        grp_ready = 1'b0;
  logic [1:0]  grp_idx;
  logic [3:0]  grp_lane_en;
  logic        grp_last;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_group_seq dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_vl(start_vl), .start_pred(start_pred),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_idx(grp_idx), .grp_lane_en(grp_lane_en), .grp_last(grp_last)
  );

  // {vl, pred, expected group count}
  localparam logic [23:0] VECS [0:7] = '{
    {5'd9,  16'hFFFF, 3'd3},
    {5'd9,  16'h01A5, 3'd3},
    {5'd4,  16'hF00F, 3'd1},
    {5'd16, 16'h0F0F, 3'd4},
    {5'd1,  16'h0001, 3'd1},
    {5'd7,  16'hFFFF, 3'd2},
    {5'd5,  16'h0010, 3'd2},
    {5'd31, 16'hFFFF, 3'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_en(input int vl, input logic [15:0] p, input int g);
    int v = (vl > 16) ? 16 : vl;
    logic [3:0] r = '0;
    for (int l = 0; l < 4; l++) begin
      int e = g * 4 + l;
      r[l] = (e < v) && p[e];
    end
    return r;
  endfunction

  task automatic run_vec(input logic [4:0] vl, input logic [15:0] pred,
                         input int ngrp, input bit stall, input bit junk);
    @(negedge clk);
    start_valid = 1'b1; start_vl = vl; start_pred = pred; grp_ready = 1'b0;
    @(negedge clk);
    if (junk) begin
      start_vl = 5'd2; start_pred = 16'h0000;
      chk(start_ready == 1'b0, "R7 start_ready busy", start_ready, 0);
    end else begin
      start_valid = 1'b0;
    end
    for (int g = 0; g < ngrp; g++) begin
      chk(grp_valid == 1'b1, "R2/R4 grp_valid", grp_valid, 1);
      chk(grp_idx == 2'(g), "R2 grp_idx", grp_idx, g);
      chk(grp_lane_en == exp_en(vl, pred, g), "R3/R9 grp_lane_en",
          grp_lane_en, exp_en(vl, pred, g));
      chk(grp_last == (g == ngrp - 1), "R5 grp_last", grp_last, (g == ngrp - 1));
      if (stall) begin
        @(negedge clk);
        chk(grp_valid && grp_idx == 2'(g) && grp_lane_en == exp_en(vl, pred, g) &&
            grp_last == (g == ngrp - 1), "R6 hold on stall", grp_idx, g);
      end
      grp_ready = 1'b1;
      @(negedge clk);
      grp_ready = 1'b0;
    end
    start_valid = 1'b0;
    chk(grp_valid == 1'b0, "R5 valid low after last", grp_valid, 0);
    chk(start_ready == 1'b1, "R5 ready after last", start_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(grp_valid == 1'b0, "R1 reset grp_valid", grp_valid, 0);
    chk(start_ready == 1'b1, "R1 reset start_ready", start_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grp_valid == 1'b0, "R1 idle after reset", grp_valid, 0);

    for (int i = 0; i < 8; i++) begin
      run_vec(VECS[i][23:19], VECS[i][18:3], int'(VECS[i][2:0]), i[0], 1'b0);
    end

    // R7: request held high through a stalled run is ignored
    run_vec(5'd9, 16'h0123, 3, 1'b1, 1'b1);

    // R8: empty vector
    @(negedge clk);
    start_valid = 1'b1; start_vl = 5'd0; start_pred = 16'hFFFF;
    @(negedge clk);
    start_valid = 1'b0;
    chk(grp_valid == 1'b0, "R8 no group for length 0", grp_valid, 0);
    chk(start_ready == 1'b1, "R8 ready after length 0", start_ready, 1);
    repeat (2) @(negedge clk);
    chk(grp_valid == 1'b0, "R8 still idle", grp_valid, 0);

    // R4: all-disabled vector still takes every group
    run_vec(5'd12, 16'h0000, 3, 1'b0, 1'b0);

    // R9: maximum length exactly
    run_vec(5'd16, 16'h8001, 4, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule